// File: doc/BRIEF.md
# Two-Wire Bus Condition Monitor

This block listens passively to a two-wire serial management bus (a clock line and a data line, both open-drain) and turns the line activity into clean, single-cycle events in the system clock domain. Both lines are first brought into the system clock domain and then debounced. The block recognises the framing conditions that bracket every transaction and keeps a flag that shows whether a transaction is in progress. It also watches for a bus that has been stuck with the clock line held low.

A framing condition is any data-line edge while the clock line is high. A falling data edge opens a transaction and a rising data edge closes it. A falling data edge that arrives while a transaction is already open is reported on its own output as a restart. If a framing condition arrives partway through a byte, the block reports it and also raises a protocol-error pulse. The clock-low watchdog uses a parameter given in system clocks. By default this parameter equals 25 ms at the configured clock rate. When the watchdog expires, the block raises a timeout flag and drops the busy flag, so every party can back off.

A controller or target uses the event pulses to frame its byte engine, and uses the busy and timeout flags to decide when it may contend for the bus.

Top module: `twowire_cond_mon`

## Requirements
- R1: While reset is held and in the first cycles after it is released, every event pulse is low, `busy_o` is low and `tout_o` is low.
- R2: With the bus idle, a falling data edge while the clock line is high produces one `start_o` pulse, and `busy_o` goes high in the same cycle as that pulse.
- R3: With `busy_o` high, a falling data edge while the clock line is high produces one `rstart_o` pulse and no `start_o` pulse, and `busy_o` stays high.
- R4: A rising data edge while the clock line is high produces one `stop_o` pulse, and `busy_o` is low from the cycle of that pulse.
- R5: Data-line changes while the clock line is low produce no event pulse and leave `busy_o` unchanged.
- R6: A level change on either line that lasts 2 system clocks or fewer is filtered out and produces no event. The filter accepts a new level only after it has been seen for 3 consecutive synchronized samples.
- R7: A start, restart or stop condition raises `err_o` for one cycle, together with its own pulse, when `busy_o` is high and 2 to 9 clock-line rising edges have been counted in the current byte frame. The frame count resets to 0 on every framing condition, and a rising edge that follows the 9th edge counts as 1 again. A condition at count 0 or 1 is legal.
- R8: `tout_o` rises once the filtered clock line has been low for `TOUT_CYCLES` consecutive system clocks, and not before.
- R9: `busy_o` drops when `tout_o` rises and stays low while `tout_o` is high. `tout_o` clears once the filtered clock line is high again.
- R10: Each event pulse lasts exactly one cycle, and at most one of `start_o`, `rstart_o` and `stop_o` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Bus clock line as sensed (asynchronous) |
| sda_i | input | 1 | Bus data line as sensed (asynchronous) |
| start_o | output | 1 | One-cycle pulse on a start condition from idle |
| rstart_o | output | 1 | One-cycle pulse on a start condition while busy |
| stop_o | output | 1 | One-cycle pulse on a stop condition |
| err_o | output | 1 | One-cycle pulse on a framing condition inside a byte |
| busy_o | output | 1 | A transaction is open |
| tout_o | output | 1 | Clock line held low past the timeout limit |

## Verification
The properties assume that the two lines never change in the same system clock. They also assume that a line does not toggle again before the debounce window has accepted its previous level. Without these assumptions, the filter could present a clock edge and a data edge in one cycle, and this would blur which condition took place. The stimulus meets both assumptions by changing only one line per step and holding each level for 16 cycles. The exception is the deliberate 2-cycle glitch, which the filter is meant to reject. The timeout scenarios hold the data line steady while the clock line is low, so the watchdog runs with no framing conditions mixed in.

// File: rtl/twowire_cond_mon.sv
module twowire_cond_mon #(
  parameter int unsigned CLK_HZ      = 100_000_000,
  parameter int unsigned TOUT_US     = 25_000,
  parameter int unsigned TOUT_CYCLES = (CLK_HZ / 1_000_000) * TOUT_US,
  parameter int unsigned SYNC_LEN    = 2,
  parameter int unsigned FILT_LEN    = 3,
  parameter int unsigned FRAME_BITS  = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic start_o,
  output logic rstart_o,
  output logic stop_o,
  output logic err_o,
  output logic busy_o,
  output logic tout_o
);

  localparam int unsigned CW = $clog2(TOUT_CYCLES + 1);
  localparam int unsigned BW = $clog2(FRAME_BITS + 1);

  logic [SYNC_LEN-1:0] scl_sy, sda_sy;
  logic [FILT_LEN-1:0] scl_win, sda_win;
  logic scl_f, sda_f, scl_d, sda_d;
  logic [BW-1:0] bitcnt;
  logic [CW-1:0] lowcnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_sy  <= '1;
      sda_sy  <= '1;
      scl_win <= '1;
      sda_win <= '1;
    end else begin
      scl_sy  <= {scl_sy[SYNC_LEN-2:0], scl_i};
      sda_sy  <= {sda_sy[SYNC_LEN-2:0], sda_i};
      scl_win <= {scl_win[FILT_LEN-2:0], scl_sy[SYNC_LEN-1]};
      sda_win <= {sda_win[FILT_LEN-2:0], sda_sy[SYNC_LEN-1]};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_f <= 1'b1;
      sda_f <= 1'b1;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      if (&scl_win) scl_f <= 1'b1;
      else if (~|scl_win) scl_f <= 1'b0;
      if (&sda_win) sda_f <= 1'b1;
      else if (~|sda_win) sda_f <= 1'b0;
      scl_d <= scl_f;
      sda_d <= sda_f;
    end
  end

  wire scl_hi     = scl_f & scl_d;
  wire scl_rise   = scl_f & ~scl_d;
  wire cond_start = scl_hi & sda_d & ~sda_f;
  wire cond_stop  = scl_hi & ~sda_d & sda_f;
  wire cond_any   = cond_start | cond_stop;
  wire mid_frame  = bitcnt > BW'(1);
  wire tout_hit   = ~scl_f & ~tout_o & (lowcnt == CW'(TOUT_CYCLES - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) bitcnt <= '0;
    else if (cond_any) bitcnt <= '0;
    else if (scl_rise) bitcnt <= (bitcnt == BW'(FRAME_BITS)) ? BW'(1) : bitcnt + BW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lowcnt <= '0;
      tout_o <= 1'b0;
    end else if (scl_f) begin
      lowcnt <= '0;
      tout_o <= 1'b0;
    end else begin
      if (lowcnt != CW'(TOUT_CYCLES)) lowcnt <= lowcnt + CW'(1);
      if (tout_hit) tout_o <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_o  <= 1'b0;
      rstart_o <= 1'b0;
      stop_o   <= 1'b0;
      err_o    <= 1'b0;
      busy_o   <= 1'b0;
    end else begin
      start_o  <= cond_start & ~busy_o;
      rstart_o <= cond_start & busy_o;
      stop_o   <= cond_stop;
      err_o    <= cond_any & busy_o & mid_frame;
      if (tout_hit) busy_o <= 1'b0;
      else if (cond_start) busy_o <= 1'b1;
      else if (cond_stop) busy_o <= 1'b0;
    end
  end

  p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> busy_o && !$past(busy_o));

  p_rstart_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rstart_o |-> busy_o && $past(busy_o));

  p_stop_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    stop_o |-> !busy_o);

  p_err_with_cond_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (rstart_o || stop_o));

  p_tout_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tout_o) |-> !$past(scl_f));

  p_tout_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tout_o |-> !busy_o);

  p_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_o, rstart_o, stop_o}));

  p_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (start_o || rstart_o || stop_o) |=> !(start_o || rstart_o || stop_o));

endmodule

// File: tb/twowire_cond_mon_bench.sv
module twowire_cond_mon_bench;
  localparam int unsigned TOUT = 200;
  localparam int unsigned HOLD = 16;
  localparam int NVEC = 29;
  // {scl, sda, start, rstart, stop, err, busy}
  localparam logic [6:0] VEC [NVEC] = '{
    7'b11_0000_0, 7'b10_1000_1, 7'b00_0000_1, 7'b01_0000_1, 7'b11_0000_1,
    7'b01_0000_1, 7'b00_0000_1, 7'b10_0000_1, 7'b00_0000_1, 7'b01_0000_1,
    7'b11_0000_1, 7'b10_0101_1, 7'b00_0000_1, 7'b10_0000_1, 7'b11_0010_0,
    7'b10_1000_1, 7'b00_0000_1, 7'b10_0000_1, 7'b00_0000_1, 7'b01_0000_1,
    7'b11_0000_1, 7'b10_0101_1, 7'b00_0000_1, 7'b01_0000_1, 7'b11_0000_1,
    7'b10_0100_1, 7'b00_0000_1, 7'b10_0000_1, 7'b11_0010_0
  };

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda = 1'b1;
  logic start_o, rstart_o, stop_o, err_o, busy_o, tout_o;
  int n_st, n_rs, n_sp, n_er, run, max_run, tests, fails, cyc;

  always #5 clk = ~clk;

  twowire_cond_mon #(.TOUT_CYCLES(TOUT)) u_twowire_cond_mon (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda),
    .start_o(start_o), .rstart_o(rstart_o), .stop_o(stop_o),
    .err_o(err_o), .busy_o(busy_o), .tout_o(tout_o));

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (rst_n) begin
      n_st <= n_st + int'(start_o);
      n_rs <= n_rs + int'(rstart_o);
      n_sp <= n_sp + int'(stop_o);
      n_er <= n_er + int'(err_o);
      if (start_o || rstart_o || stop_o || err_o) begin
        run <= run + 1;
        if (run + 1 > max_run) max_run <= run + 1;
      end else run <= 0;
    end
  end

  task automatic chk(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clr();
    n_st = 0; n_rs = 0; n_sp = 0; n_er = 0;
  endtask

  task automatic step(logic c, logic d, int n);
    @(negedge clk);
    scl = c;
    sda = d;
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic clk_bits(int k);
    for (int i = 0; i < k; i++) begin
      step(1'b0, 1'b0, HOLD);
      step(1'b1, 1'b0, HOLD);
    end
  endtask

  initial begin
    cyc = 0; tests = 0; fails = 0; run = 0; max_run = 0;
    clr();
    repeat (4) @(negedge clk);
    chk("R1 busy in reset", int'(busy_o), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 pulses after reset", int'(start_o | rstart_o | stop_o | err_o), 0);
    chk("R1 busy after reset", int'(busy_o), 0);
    chk("R1 tout after reset", int'(tout_o), 0);

    for (int v = 0; v < NVEC; v++) begin
      clr();
      step(VEC[v][6], VEC[v][5], HOLD);
      chk($sformatf("R2 start v%0d", v), n_st, int'(VEC[v][4]));
      chk($sformatf("R3 rstart v%0d", v), n_rs, int'(VEC[v][3]));
      chk($sformatf("R4 stop v%0d", v), n_sp, int'(VEC[v][2]));
      chk($sformatf("R7 err v%0d", v), n_er, int'(VEC[v][1]));
      chk($sformatf("R5 busy v%0d", v), int'(busy_o), int'(VEC[v][0]));
    end

    // R6: 2-cycle data glitch while idle
    clr();
    @(negedge clk); sda = 1'b0;
    repeat (2) @(negedge clk); sda = 1'b1;
    repeat (HOLD) @(negedge clk);
    #1;
    chk("R6 glitch start", n_st + n_rs + n_sp, 0);
    chk("R6 glitch busy", int'(busy_o), 0);

    // R7: wrap after 9th rise, stop at count 1 is legal
    clr();
    step(1'b1, 1'b0, HOLD);
    clk_bits(10);
    step(1'b1, 1'b1, HOLD);
    chk("R7 wrap stop", n_sp, 1);
    chk("R7 wrap err", n_er, 0);
    // R7: stop after 8 rises is flagged
    clr();
    step(1'b1, 1'b0, HOLD);
    clk_bits(8);
    step(1'b1, 1'b1, HOLD);
    chk("R7 mid-byte stop", n_sp, 1);
    chk("R7 mid-byte err", n_er, 1);

    // R8/R9: clock-low timeout
    step(1'b1, 1'b0, HOLD);
    step(1'b0, 1'b0, 150);
    chk("R8 tout early", int'(tout_o), 0);
    chk("R8 busy before tout", int'(busy_o), 1);
    step(1'b0, 1'b0, 80);
    chk("R8 tout set", int'(tout_o), 1);
    chk("R9 busy dropped", int'(busy_o), 0);
    step(1'b1, 1'b0, HOLD);
    chk("R9 tout cleared", int'(tout_o), 0);
    step(1'b1, 1'b1, HOLD);

    chk("R10 pulse width", max_run, 1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    wait (cyc > 100000);
    fails++;
    tests++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule